// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block sits on the host side of a word-wide parallel flash. Once a program or erase command has been sent to the device by other logic, a one-cycle start pulse hands the poller the kind of operation, the address and the intended 16-bit word. The poller then reads the device over a simple synchronous read handshake, one read at a time. On each status read it looks at two things. The polled bits are bit 7 and bit 15, and the poller compares them with the matching bits of the intended word. The fault bits are bit 5 and bit 13.

The operation ends with a one-cycle done pulse and a 2-bit result. The codes are 0 for success, 1 for a device-reported fault, 2 for a watchdog expiry and 3 for a failed read-back. After a successful program, one more read fetches the full word and compares it with the intended word. An erase, whether of one sector or of the whole device, is judged only on its status bits. Its reads go to the even word address that contains the given address.

Top module: `flash_poll_checker`

## Requirements
- R1: While reset is held and just after it is released, `rd_req`, `done` and `busy` are 0 and `result` is 0.
- R2: In program mode every read goes to `start_addr` unchanged. A status read has bit 7 equal to intended bit 7, bit 15 equal to intended bit 15, and bits 5 and 13 both 0. Such a read ends polling and starts one read-back read of the same address.
- R3: In erase mode every read goes to `start_addr` with bit 0 cleared, and `start_word` is ignored. Polling ends when bits 7 and 15 both read 1, after which success (code 0) is reported with no read-back. A fully erased word (all ones) has bits 5 and 13 set, so it costs one confirming read under R4.
- R4: A status read with bit 5 or bit 13 set causes exactly one further read. If that read matches under the rule of R2 (program) or R3 (erase), the flow continues as on a match, whatever its fault bits show. Otherwise code 1 is reported.
- R5: After `wdog_limit` status reads with neither a match nor a set fault bit, code 2 is reported. A limit of 0 acts as 1. A fault bit on the last allowed read still leads to the confirming read of R4, not to code 2.
- R6: The read-back read compares all 16 bits with the intended word. It gives code 0 when they are equal and code 3 otherwise.
- R7: `rd_req` is a one-cycle pulse. No new `rd_req` is raised until the `rd_valid` of the previous read has been received, and `rd_valid` while no read is outstanding is ignored.
- R8: `done` is high for exactly one cycle per operation. `busy` is high from the cycle after an accepted start until `done`. A start while `busy` is ignored and leaves the read address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin polling |
| start_erase | input | 1 | 1 = erase operation, 0 = program operation |
| start_addr | input | ADDR_W | Word address of the programmed word or inside the erased region |
| start_word | input | 16 | Intended word (program only) |
| wdog_limit | input | WDOG_W | Maximum status reads without an outcome |
| rd_req | output | 1 | Read strobe, one cycle |
| rd_addr | output | ADDR_W | Read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 16 | Read data |
| done | output | 1 | Completion pulse |
| result | output | 2 | 0 ok, 1 device error, 2 timeout, 3 read-back mismatch |
| busy | output | 1 | Operation in progress |

## Verification
Two events can land on the same returned word: the watchdog reaching its last allowed read, and a set fault bit. A further pair is a polled-bit match arriving in the same word as a fault bit. The bench scripts the memory model to return a fault bit on exactly the final read the limit allows. It then checks that a confirming read follows, and that its result (code 0 or 1, never 2) and the read count follow R4. It also sweeps intended words whose own bits 5 and 13 are set, so the completion word itself carries a fault bit, and checks that exactly one extra read is spent.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  localparam int WORD_W  = 16;
  localparam int POLL_LO = 7;
  localparam int POLL_HI = 15;
  localparam int ERR_LO  = 5;
  localparam int ERR_HI  = 13;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_DEVERR  = 2'd1,
    RES_TIMEOUT = 2'd2,
    RES_VERIFY  = 2'd3
  } result_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } state_e;

  typedef enum logic [1:0] {
    PH_POLL    = 2'd0,
    PH_CONFIRM = 2'd1,
    PH_VERIFY  = 2'd2
  } phase_e;

  // polled bits agree with the target word
  function automatic logic poll_match(logic [WORD_W-1:0] d, logic [WORD_W-1:0] t);
    return (d[POLL_LO] == t[POLL_LO]) && (d[POLL_HI] == t[POLL_HI]);
  endfunction

  // device fault indication in either byte
  function automatic logic fault_seen(logic [WORD_W-1:0] d);
    return d[ERR_LO] | d[ERR_HI];
  endfunction

  // erase completes towards all ones; program towards the written word
  function automatic logic [WORD_W-1:0] poll_target(logic erase, logic [WORD_W-1:0] w);
    return erase ? {WORD_W{1'b1}} : w;
  endfunction

endpackage

// File: rtl/fpc_status_eval.sv
module fpc_status_eval
  import fpc_pkg::*;
(
  input  logic [WORD_W-1:0] rd_data,
  input  logic [WORD_W-1:0] target,
  output logic              poll_ok,
  output logic              err_seen,
  output logic              word_ok
);

  assign poll_ok  = poll_match(rd_data, target);
  assign err_seen = fault_seen(rd_data);
  assign word_ok  = (rd_data == target);

endmodule

// File: rtl/fpc_watchdog.sv
module fpc_watchdog #(
  parameter int WDOG_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [WDOG_W-1:0] limit,
  output logic              last
);

  localparam int CNT_W = WDOG_W + 1;

  function automatic logic [CNT_W-1:0] eff_limit(logic [WDOG_W-1:0] l);
    return (l == '0) ? CNT_W'(1) : {1'b0, l};
  endfunction

  logic [WDOG_W-1:0] cnt_q;

  assign last = ({1'b0, cnt_q} + CNT_W'(1)) >= eff_limit(limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (step)       cnt_q <= cnt_q + WDOG_W'(1);
  end

  // R5
  wdog_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |-> ({1'b0, cnt_q} < eff_limit(limit)));

endmodule

// File: rtl/fpc_sequencer.sv
module fpc_sequencer
  import fpc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_ok,
  input  logic    is_erase,
  input  logic    rd_valid,
  input  logic    poll_ok,
  input  logic    err_seen,
  input  logic    word_ok,
  input  logic    wd_last,
  output logic    rd_req,
  output logic    busy,
  output logic    done,
  output result_e result,
  output logic    wd_clear,
  output logic    wd_step
);

  state_e  state_q, state_d;
  phase_e  phase_q, phase_d;
  logic    fin;
  result_e fin_code;
  logic    accept;

  assign accept   = (state_q == ST_WAIT) && rd_valid;
  assign rd_req   = (state_q == ST_ISSUE);
  assign busy     = (state_q != ST_IDLE);
  assign wd_clear = start_ok;

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    fin      = 1'b0;
    fin_code = RES_OK;
    wd_step  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ok) begin
          state_d = ST_ISSUE;
          phase_d = PH_POLL;
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (rd_valid) begin
          state_d = ST_ISSUE;
          unique case (phase_q)
            PH_POLL: begin
              if (err_seen) phase_d = PH_CONFIRM;
              else if (poll_ok) begin
                if (is_erase) fin = 1'b1;
                else          phase_d = PH_VERIFY;
              end else if (wd_last) begin
                fin      = 1'b1;
                fin_code = RES_TIMEOUT;
              end else wd_step = 1'b1;
            end
            PH_CONFIRM: begin
              if (poll_ok) begin
                if (is_erase) fin = 1'b1;
                else          phase_d = PH_VERIFY;
              end else begin
                fin      = 1'b1;
                fin_code = RES_DEVERR;
              end
            end
            default: begin
              fin      = 1'b1;
              fin_code = word_ok ? RES_OK : RES_VERIFY;
            end
          endcase
          if (fin) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_POLL;
      done    <= 1'b0;
      result  <= RES_OK;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      done    <= fin;
      if (fin) result <= fin_code;
    end
  end

  // R7
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_req && !rd_valid) |=> !rd_req);

  // R2
  first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> rd_req);

  // R4
  confirm_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && phase_q == PH_CONFIRM) |=> (done || phase_q == PH_VERIFY));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/flash_poll_checker.sv
module flash_poll_checker
  import fpc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int WDOG_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_erase,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [15:0]       start_word,
  input  logic [WDOG_W-1:0] wdog_limit,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [15:0]       rd_data,
  output logic              done,
  output logic [1:0]        result,
  output logic              busy
);

  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] target_q;
  logic              erase_q;
  logic [WDOG_W-1:0] limit_q;
  logic              start_ok;
  logic              poll_ok, err_seen, word_ok;
  logic              wd_clear, wd_step, wd_last;
  result_e           res_e;

  assign start_ok = start && !busy;
  assign rd_addr  = addr_q;
  assign result   = res_e;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      target_q <= '0;
      erase_q  <= 1'b0;
      limit_q  <= '0;
    end else if (start_ok) begin
      addr_q   <= start_erase ? {start_addr[ADDR_W-1:1], 1'b0} : start_addr;
      target_q <= poll_target(start_erase, start_word);
      erase_q  <= start_erase;
      limit_q  <= wdog_limit;
    end
  end

  fpc_status_eval u_eval (
    .rd_data  (rd_data),
    .target   (target_q),
    .poll_ok  (poll_ok),
    .err_seen (err_seen),
    .word_ok  (word_ok)
  );

  fpc_watchdog #(.WDOG_W(WDOG_W)) u_wdog (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (wd_clear),
    .step  (wd_step),
    .limit (limit_q),
    .last  (wd_last)
  );

  fpc_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ok (start_ok),
    .is_erase (erase_q),
    .rd_valid (rd_valid),
    .poll_ok  (poll_ok),
    .err_seen (err_seen),
    .word_ok  (word_ok),
    .wd_last  (wd_last),
    .rd_req   (rd_req),
    .busy     (busy),
    .done     (done),
    .result   (res_e),
    .wd_clear (wd_clear),
    .wd_step  (wd_step)
  );

  // R3
  erase_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && erase_q) |-> !rd_addr[0]);

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(rd_addr));

  // R6
  verify_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 2'd3) |-> !erase_q);

endmodule

// File: tb/flash_poll_checker_tb.sv
module flash_poll_checker_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, start_erase;
  logic [19:0] start_addr;
  logic [15:0] start_word;
  logic [11:0] wdog_limit;
  logic        rd_req;
  logic [19:0] rd_addr;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        done;
  logic [1:0]  result;
  logic        busy;

  int checks = 0;
  int errors = 0;

  // memory model state
  int          lat = 1;
  logic [15:0] scr [16];
  int          sidx = 0;
  int          nreads = 0;
  int          addr_bad = 0;
  int          proto_bad = 0;
  int          done_cnt = 0;
  bit          outstanding = 0;
  int          wait_left = 0;
  logic [19:0] exp_addr = '0;
  bit          inject = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_poll_checker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_erase(start_erase),
    .start_addr(start_addr), .start_word(start_word), .wdog_limit(wdog_limit),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .result(result), .busy(busy)
  );

  function automatic logic [15:0] busy_of(logic [15:0] w);
    return (w ^ 16'h8080) & 16'hDFDF;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // responder: one read at a time, data after lat cycles
  initial begin
    rd_valid = 1'b0;
    rd_data  = '0;
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      if (inject) begin
        rd_valid = 1'b1;
        rd_data  = 16'hFFFF;
        inject   = 0;
      end
      if (outstanding) begin
        if (wait_left <= 1) begin
          rd_valid    = 1'b1;
          rd_data     = scr[(sidx < 16) ? sidx : 15];
          sidx++;
          outstanding = 0;
        end else wait_left--;
      end
      if (rd_req === 1'b1) begin
        if (outstanding) proto_bad++;
        outstanding = 1;
        wait_left   = lat;
        nreads++;
        if (rd_addr !== exp_addr) addr_bad++;
      end
      if (done === 1'b1) done_cnt++;
    end
  end

  task automatic run_case(input bit erase, input logic [19:0] addr,
                          input logic [15:0] word, input logic [11:0] lim,
                          input bit poke, input int exp_code,
                          input int exp_reads, input string req);
    int cyc;
    @(negedge clk);
    sidx = 0; nreads = 0; addr_bad = 0; proto_bad = 0; done_cnt = 0;
    exp_addr    = erase ? {addr[19:1], 1'b0} : addr;
    start       = 1'b1;
    start_erase = erase;
    start_addr  = addr;
    start_word  = word;
    wdog_limit  = lim;
    @(negedge clk);
    start       = 1'b0;
    start_addr  = ~addr;
    start_word  = ~word;
    start_erase = ~erase;
    if (poke) begin
      repeat (2) @(negedge clk);
      start      = 1'b1;
      start_addr = addr ^ 20'h6;
      @(negedge clk);
      start      = 1'b0;
    end
    cyc = 0;
    while (done !== 1'b1 && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done === 1'b1, req, "done seen", done, 1);
    chk(result == 2'(exp_code), req, "result code", result, exp_code);
    chk(nreads == exp_reads, req, "read count", nreads, exp_reads);
    chk(addr_bad == 0, req, "read address mismatches", addr_bad, 0);
    chk(proto_bad == 0, "R7", "overlapping reads", proto_bad, 0);
    chk(busy === 1'b0, "R8", "busy at done", busy, 0);
    @(negedge clk);
    chk(done === 1'b0 && done_cnt == 1, "R8", "done pulse count", done_cnt, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] w;
    int rd;
    rst_n = 1'b0; start = 1'b0; start_erase = 1'b0;
    start_addr = '0; start_word = '0; wdog_limit = '0;
    for (int i = 0; i < 16; i++) scr[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_req === 1'b0, "R1", "rd_req in reset", rd_req, 0);
    chk(done === 1'b0, "R1", "done in reset", done, 0);
    chk(busy === 1'b0, "R1", "busy in reset", busy, 0);
    chk(result === 2'd0, "R1", "result in reset", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_req === 1'b0 && busy === 1'b0, "R1", "idle after reset", busy, 0);

    // R2 sweep: polled/fault bit combos of the intended word, busy length, latency
    for (int m = 0; m < 16; m++) begin
      for (int b = 0; b < 3; b++) begin
        w = 16'h1A4C | (m[0] ? 16'h0080 : 16'h0) | (m[1] ? 16'h8000 : 16'h0)
                     | (m[2] ? 16'h0020 : 16'h0) | (m[3] ? 16'h2000 : 16'h0);
        lat = 1 + (m % 3);
        for (int i = 0; i < 16; i++) scr[i] = (i < b) ? busy_of(w) : w;
        rd = b + 1 + ((m[2] || m[3]) ? 1 : 0) + 1;
        run_case(1'b0, 20'h000A5 + 20'(m), w, 12'd8, 1'b0, 0, rd, "R2");
      end
    end

    // R6 read-back mismatch on every single bit
    lat = 1;
    for (int k = 0; k < 16; k++) begin
      w = 16'h1C5A;
      scr[0] = w;
      for (int i = 1; i < 16; i++) scr[i] = w ^ (16'h1 << k);
      run_case(1'b0, 20'h01234, w, 12'd4, 1'b0, 3, 2, "R6");
    end

    // R3 erase: odd/even address, all-ones vs fault-clear completion word
    for (int b = 0; b < 4; b++) begin
      lat = 1 + b % 2;
      for (int i = 0; i < 16; i++) scr[i] = (i < b) ? 16'h5F5F : 16'hFFFF;
      run_case(1'b1, 20'h40001 + 20'(b), 16'h1234, 12'd8, 1'b0, 0, b + 2, "R3");
      for (int i = 0; i < 16; i++) scr[i] = (i < b) ? 16'h5F5F : 16'hDFDF;
      run_case(1'b1, 20'h40011 + 20'(b), 16'h0000, 12'd8, 1'b0, 0, b + 1, "R3");
    end

    // R4 erase fault persists
    lat = 2;
    scr[0] = 16'h5F5F;
    for (int i = 1; i < 16; i++) scr[i] = 16'h0020;
    run_case(1'b1, 20'h00777, 16'hFFFF, 12'd8, 1'b0, 1, 3, "R4");

    // R4 program fault then match on the confirming read
    w = 16'h1A4C;
    scr[0] = busy_of(w); scr[1] = busy_of(w) | 16'h2000;
    for (int i = 2; i < 16; i++) scr[i] = w;
    run_case(1'b0, 20'h00100, w, 12'd8, 1'b0, 0, 4, "R4");

    // R4 program fault confirmed
    scr[0] = busy_of(w);
    for (int i = 1; i < 16; i++) scr[i] = busy_of(w) | 16'h0020;
    run_case(1'b0, 20'h00101, w, 12'd8, 1'b0, 1, 3, "R4");

    // R5 timeout for several limits, 0 behaves as 1
    for (int l = 0; l < 5; l++) begin
      for (int i = 0; i < 16; i++) scr[i] = busy_of(w);
      run_case(1'b0, 20'h00200, w, 12'(l), 1'b0, 2, (l == 0) ? 1 : l, "R5");
    end

    // R5 fault on the final allowed read: confirm succeeds
    scr[0] = busy_of(w); scr[1] = busy_of(w) | 16'h0020;
    for (int i = 2; i < 16; i++) scr[i] = w;
    run_case(1'b0, 20'h00300, w, 12'd2, 1'b0, 0, 4, "R5");

    // R5 fault on the final allowed read: confirm fails gives device error
    scr[0] = busy_of(w); scr[1] = busy_of(w) | 16'h0020;
    for (int i = 2; i < 16; i++) scr[i] = busy_of(w);
    run_case(1'b0, 20'h00301, w, 12'd2, 1'b0, 1, 3, "R5");

    // R5 match exactly on the final allowed read
    scr[0] = busy_of(w); scr[1] = busy_of(w);
    for (int i = 2; i < 16; i++) scr[i] = w;
    run_case(1'b0, 20'h00302, w, 12'd3, 1'b0, 0, 4, "R5");

    // R8 start while busy ignored
    lat = 2;
    for (int i = 0; i < 16; i++) scr[i] = (i < 3) ? busy_of(w) : w;
    run_case(1'b0, 20'h00400, w, 12'd8, 1'b1, 0, 5, "R8");

    // R7 stray rd_valid while idle is ignored
    @(negedge clk);
    done_cnt = 0; nreads = 0;
    inject = 1;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && done_cnt == 0, "R7", "stray rd_valid effect", done_cnt, 0);
    chk(nreads == 0, "R7", "reads after stray rd_valid", nreads, 0);
    lat = 1;
    for (int i = 0; i < 16; i++) scr[i] = w;
    run_case(1'b0, 20'h00500, w, 12'd8, 1'b0, 0, 2, "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule